// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Edge and Level Sensing

This block collects every interrupt source of a small processor and presents one winning request at a time. The sources are an unmaskable falling-edge input, eight active-low external lines and nineteen on-chip peripheral requests. A per-line mode bit makes each external line level-sensed or falling-edge-sensed. A per-line enable gates each external line. A global mask bit, kept inside the block and writable by the processor, gates every source except the unmaskable one.

The winner is registered into a request, a vector number and a vector-table byte address, which is always twice the vector number. The processor answers with a one-cycle acknowledge. The acknowledge sets the global mask, clears the capture flop of the granted source and frees the arbiter for the next decision. Edge events are captured even while the mask is set, so they are served once the processor clears it. Level requests are not stored: a line that returns high before acceptance leaves nothing behind.

All pin inputs pass through a synchronizer. The request output is formed from registered state, and it drops as soon as the held source stops qualifying.

Top module: `prio_intc`

## Requirements
- R1: After reset, `req_o` is 0, `vec_num_o` and `vec_addr_o` are 0, and `mask_o` is 1.
- R2: A falling edge on `nmi_n` raises a request with vector number 3 and address 6, even while `mask_o` is 1.
- R3: After an unmaskable request has been acknowledged, with the mask at 1, a new falling edge on `nmi_n` is granted again.
- R4: External line n with `irq_sense[n]`=0 is level-sensed and active low. While the pin is low, `irq_en[n]` is 1 and the mask is 0, it requests vector 4+n at address 2*(4+n). With `irq_en[n]`=0 it raises nothing.
- R5: A level-sensed line that goes low and returns high while masked leaves no request once the mask is cleared.
- R6: With `irq_sense[n]`=1, a falling edge is captured only if `irq_en[n]` is 1 at the time of the edge. An edge seen while disabled raises nothing after a later enable.
- R7: An enabled falling edge is captured while the mask is 1. It raises nothing until the mask is cleared, then it is granted.
- R8: Fixed priority: the unmaskable source first, then external lines 0 (highest) to 7, then internal sources 0 (highest) to 18.
- R9: Internal source k requests vector 12+k at address 2*(12+k), only while `int_req[k]`, `int_en[k]` and mask 0 all hold.
- R10: An acknowledge while `req_o` is 1 sets the mask to 1 and clears the capture flop of the granted edge or unmaskable source, so that source does not request again without a new edge.
- R11: While `req_o` is 1 and no acknowledge is given, `vec_num_o` and `vec_addr_o` hold their values, even if a higher-priority source arrives.
- R12: `mask_wr`=1 loads `mask_wdata` into the mask. An acknowledge in the same cycle takes precedence and sets the mask to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_n | input | 1 | Unmaskable request pin, falling-edge sensed |
| irq_n | input | 8 | External request pins, active low |
| irq_sense | input | 8 | Per-line mode: 1 falling edge, 0 low level |
| irq_en | input | 8 | Per-line enable for external lines |
| int_req | input | 19 | On-chip peripheral request flags |
| int_en | input | 19 | Per-peripheral enables |
| mask_wr | input | 1 | Write strobe for the global mask |
| mask_wdata | input | 1 | Value written to the global mask |
| ack | input | 1 | Acknowledge of the presented request |
| req_o | output | 1 | Interrupt request to the processor |
| vec_num_o | output | 8 | Vector number of the presented request |
| vec_addr_o | output | 16 | Vector-table byte address (vector number times two) |
| mask_o | output | 1 | Current global mask bit |

## Verification
The hardest case to reach is a higher-priority arrival while a lower request is already presented and not yet acknowledged. The stimulus waits until an external level request is on the outputs. It then delays the acknowledge for several cycles and drops a pulse on the unmaskable pin during that window. The scoreboard checks that the vector stays unchanged until the acknowledge, and that the unmaskable grant follows even though the acknowledge has just set the mask. Edges captured while masked are covered by stacking several sources behind a set mask and releasing them one grant at a time.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Maps a flat source index (0 = unmaskable, then external, then internal)
  // to its vector number.
  function automatic int src_vector(input int idx, input int n_ext,
                                    input int nmi_vec, input int ext_base,
                                    input int int_base);
    if (idx == 0)
      return nmi_vec;
    else if (idx <= n_ext)
      return ext_base + idx - 1;
    else
      return int_base + idx - 1 - n_ext;
  endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // Idle level of every pin is high, so the chain resets to ones.
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '1;
    end else begin
      pipe_q[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/intc_nmi.sv
module intc_nmi (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic clr,
  output logic pend
);
  logic prev_q, latch_q, fall;

  assign fall = prev_q & ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= pin_s;
      latch_q <= (latch_q & ~clr) | fall;
    end
  end

  assign pend = latch_q;

  AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (clr && !fall) |=> !pend); // R10
endmodule

// File: rtl/intc_ext_bank.sv
module intc_ext_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] sense_edge,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] latch_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic fall;
    assign fall = prev_q[i] & ~pin_s[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i]  <= 1'b1;
        latch_q[i] <= 1'b0;
      end else begin
        prev_q[i]  <= pin_s[i];
        // capture only while enabled; flop stays empty in level mode
        latch_q[i] <= ((latch_q[i] & ~clr[i]) | (fall & en[i])) & sense_edge[i];
      end
    end

    assign pend[i] = en[i] & (sense_edge[i] ? latch_q[i] : ~pin_s[i]);

    AST_EDGE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      $rose(latch_q[i]) |-> $past(en[i])); // R6
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_EXT        = 8,
  parameter int N_INT        = 19,
  parameter int SYNC_STAGES  = 2,
  parameter int NMI_VEC      = 3,
  parameter int EXT_VEC_BASE = 4,
  parameter int INT_VEC_BASE = 12,
  parameter int VEC_W        = 8,
  parameter int ADDR_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_n,
  input  logic [N_EXT-1:0]  irq_n,
  input  logic [N_EXT-1:0]  irq_sense,
  input  logic [N_EXT-1:0]  irq_en,
  input  logic [N_INT-1:0]  int_req,
  input  logic [N_INT-1:0]  int_en,
  input  logic              mask_wr,
  input  logic              mask_wdata,
  input  logic              ack,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              mask_o
);
  localparam int NSRC  = 1 + N_EXT + N_INT;
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [N_EXT:0]     pins_s;
  logic               nmi_pend;
  logic [N_EXT-1:0]   ext_pend;
  logic [N_EXT-1:0]   ext_clr;
  logic               nmi_clr;
  logic [NSRC-1:0]    pend;
  logic               any_pend;
  logic [IDX_W-1:0]   win_idx;
  logic [VEC_W-1:0]   win_vec;
  logic [ADDR_W-1:0]  win_vec_ext;
  logic [ADDR_W-1:0]  win_addr;

  logic               req_q;
  logic [IDX_W-1:0]   sel_q;
  logic [VEC_W-1:0]   vec_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               mask_q;
  logic               held_pend;
  logic               ack_take;

  // pin synchronizer: bit 0 unmaskable, bits 1.. external lines
  intc_sync #(.W(N_EXT + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({irq_n, nmi_n}),
    .dout (pins_s)
  );

  intc_nmi u_nmi (
    .clk   (clk),
    .rst   (rst),
    .pin_s (pins_s[0]),
    .clr   (nmi_clr),
    .pend  (nmi_pend)
  );

  intc_ext_bank #(.N(N_EXT)) u_ext (
    .clk        (clk),
    .rst        (rst),
    .pin_s      (pins_s[N_EXT:1]),
    .sense_edge (irq_sense),
    .en         (irq_en),
    .clr        (ext_clr),
    .pend       (ext_pend)
  );

  // flat pending vector in priority order, mask applied to maskable part
  assign pend[0]              = nmi_pend;
  assign pend[N_EXT:1]        = ext_pend & {N_EXT{~mask_q}};
  assign pend[NSRC-1:N_EXT+1] = int_req & int_en & {N_INT{~mask_q}};

  intc_prio #(.N(NSRC)) u_prio (
    .req (pend),
    .any (any_pend),
    .idx (win_idx)
  );

  assign win_vec     = VEC_W'(intc_pkg::src_vector(int'(win_idx), N_EXT, NMI_VEC,
                                                   EXT_VEC_BASE, INT_VEC_BASE));
  assign win_vec_ext = ADDR_W'(win_vec);
  assign win_addr    = {win_vec_ext[ADDR_W-2:0], 1'b0};

  assign held_pend = pend[sel_q];
  assign req_o     = req_q & held_pend;
  assign ack_take  = ack & req_o;

  // capture-flop clears for the granted source
  assign nmi_clr = ack_take && (sel_q == IDX_W'(0));
  for (genvar i = 0; i < N_EXT; i++) begin : g_clr
    assign ext_clr[i] = ack_take && (sel_q == IDX_W'(i + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      sel_q  <= '0;
      vec_q  <= '0;
      addr_q <= '0;
      mask_q <= 1'b1;
    end else begin
      if (ack_take)
        mask_q <= 1'b1;
      else if (mask_wr)
        mask_q <= mask_wdata;

      if (ack_take || (req_q && !held_pend)) begin
        req_q <= 1'b0;
      end else if (!req_q && any_pend) begin
        req_q  <= 1'b1;
        sel_q  <= win_idx;
        vec_q  <= win_vec;
        addr_q <= win_addr;
      end
    end
  end

  assign vec_num_o  = vec_q;
  assign vec_addr_o = addr_q;
  assign mask_o     = mask_q;

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
    (!req_q && nmi_pend) |=> (req_o && vec_num_o == VEC_W'(NMI_VEC))); // R8

  AST_MASK_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack && req_o) |=> mask_o); // R10

  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack) |=> ($stable(vec_num_o) && $stable(vec_addr_o))); // R11

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req_o && mask_o) |-> (vec_num_o == VEC_W'(NMI_VEC))); // R9
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_n = 1'b1;
  logic [7:0]  irq_n = '1;
  logic [7:0]  irq_sense = '0;
  logic [7:0]  irq_en = '1;
  logic [18:0] int_req = '0;
  logic [18:0] int_en = '0;
  logic        mask_wr = 1'b0;
  logic        mask_wdata = 1'b0;
  logic        ack = 1'b0;
  logic        req_o;
  logic [7:0]  vec_num_o;
  logic [15:0] vec_addr_o;
  logic        mask_o;

  int n_chk = 0;
  int n_err = 0;
  int hold_cycles = 0;
  int    exp_vec[$];
  string exp_tag[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .irq_n(irq_n), .irq_sense(irq_sense),
    .irq_en(irq_en), .int_req(int_req), .int_en(int_en), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .ack(ack), .req_o(req_o), .vec_num_o(vec_num_o),
    .vec_addr_o(vec_addr_o), .mask_o(mask_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mask(input bit v);
    mask_wr = 1'b1; mask_wdata = v;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic expect_grant(input int v, input string tag);
    exp_vec.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic drain();
    while (exp_vec.size() != 0 || ack) @(negedge clk);
    cyc(2);
  endtask

  task automatic pulse_nmi();
    nmi_n = 1'b0; cyc(3); nmi_n = 1'b1;
  endtask

  task automatic pulse_irq(input int n);
    irq_n[n] = 1'b0; cyc(3); irq_n[n] = 1'b1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // monitor: pops expected grants and acknowledges each presented request
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && req_o && !ack) begin
        if (exp_vec.size() == 0) begin
          chk(1'b0, "R10 unexpected request", int'(vec_num_o), -1);
        end else begin
          int v;
          int e;
          string t;
          v = int'(vec_num_o);
          for (int k = 0; k < hold_cycles; k++) begin
            @(negedge clk);
            chk(req_o && int'(vec_num_o) == v, "R11 vector held", int'(vec_num_o), v);
          end
          e = exp_vec.pop_front();
          t = exp_tag.pop_front();
          chk(int'(vec_num_o) == e, {t, " vector"}, int'(vec_num_o), e);
          chk(int'(vec_addr_o) == 2 * e, {t, " address"}, int'(vec_addr_o), 2 * e);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_o == 1'b0, "R1 req", int'(req_o), 0);
    chk(mask_o == 1'b1, "R1 mask", int'(mask_o), 1);
    chk(vec_num_o == 0 && vec_addr_o == 0, "R1 vector", int'(vec_num_o), 0);

    // R2: unmaskable while mask is 1
    expect_grant(3, "R2");
    pulse_nmi();
    drain();
    chk(mask_o == 1'b1, "R10 mask after ack", int'(mask_o), 1);
    cyc(8);
    chk(req_o == 1'b0, "R10 no repeat", int'(req_o), 0);

    // R3: nested unmaskable after acceptance
    expect_grant(3, "R3");
    pulse_nmi();
    drain();

    // R4: level line 3
    irq_n[3] = 1'b0;
    expect_grant(7, "R4 line3");
    set_mask(1'b0);
    drain();
    chk(mask_o == 1'b1, "R10 mask set", int'(mask_o), 1);
    irq_n[3] = 1'b1;
    cyc(6);
    set_mask(1'b0);
    chk(mask_o == 1'b0, "R12 mask write", int'(mask_o), 0);
    cyc(6);
    chk(req_o == 1'b0, "R4 released", int'(req_o), 0);

    // R4: disabled level line raises nothing, then enabled
    irq_en[5] = 1'b0;
    irq_n[5] = 1'b0;
    cyc(8);
    chk(req_o == 1'b0, "R4 disabled", int'(req_o), 0);
    expect_grant(9, "R4 line5");
    irq_en[5] = 1'b1;
    drain();
    irq_n[5] = 1'b1;
    cyc(5);

    // R5: level pulse while masked leaves nothing
    irq_n[6] = 1'b0;
    cyc(6);
    irq_n[6] = 1'b1;
    cyc(6);
    set_mask(1'b0);
    cyc(8);
    chk(req_o == 1'b0, "R5 level not held", int'(req_o), 0);

    // R6: edge while disabled is not captured
    set_mask(1'b1);
    irq_sense[1] = 1'b1;
    irq_en[1] = 1'b0;
    pulse_irq(1);
    cyc(6);
    irq_en[1] = 1'b1;
    set_mask(1'b0);
    cyc(8);
    chk(req_o == 1'b0, "R6 edge while disabled", int'(req_o), 0);

    // R7: edge captured while masked, served after unmask
    set_mask(1'b1);
    pulse_irq(1);
    cyc(6);
    chk(req_o == 1'b0, "R7 masked quiet", int'(req_o), 0);
    expect_grant(5, "R7 line1");
    set_mask(1'b0);
    drain();
    set_mask(1'b0);
    cyc(8);
    chk(req_o == 1'b0, "R10 edge flop cleared", int'(req_o), 0);

    // R8: stacked sources released one grant at a time
    set_mask(1'b1);
    irq_sense[2] = 1'b1;
    irq_sense[5] = 1'b1;
    irq_n[2] = 1'b0; irq_n[5] = 1'b0;
    cyc(3);
    irq_n[2] = 1'b1; irq_n[5] = 1'b1;
    irq_n[7] = 1'b0;
    int_en[0] = 1'b1; int_req[0] = 1'b1;
    cyc(6);
    expect_grant(6, "R8 line2 first");
    set_mask(1'b0);
    drain();
    expect_grant(9, "R8 line5 second");
    set_mask(1'b0);
    drain();
    expect_grant(11, "R8 line7 third");
    set_mask(1'b0);
    drain();
    irq_n[7] = 1'b1;
    cyc(6);
    expect_grant(12, "R8 internal0 last");
    set_mask(1'b0);
    drain();
    int_req[0] = 1'b0;
    cyc(4);

    // R9: internal source 18 gated by its enable
    int_req[18] = 1'b1;
    set_mask(1'b0);
    cyc(8);
    chk(req_o == 1'b0, "R9 disabled internal", int'(req_o), 0);
    expect_grant(30, "R9 internal18");
    int_en[18] = 1'b1;
    drain();
    int_req[18] = 1'b0;
    cyc(4);

    // R11: held request keeps its vector while the unmaskable pin fires
    set_mask(1'b1);
    irq_sense[0] = 1'b0;
    irq_n[0] = 1'b0;
    hold_cycles = 8;
    expect_grant(4, "R11 line0 held");
    expect_grant(3, "R11 unmaskable after");
    set_mask(1'b0);
    while (!req_o) @(negedge clk);
    pulse_nmi();
    drain();
    hold_cycles = 0;
    irq_n[0] = 1'b1;
    cyc(6);
    chk(req_o == 1'b0, "R10 idle at end", int'(req_o), 0);

    summary();
  end
endmodule